// File: doc/BRIEF.md
# PIRQ Interrupt Line Router

This block sits between eight PCI interrupt request levels (PIRQ A to H), one ACPI system control interrupt (SCI) level and the interrupt controllers of the platform. It produces sixteen legacy PIC request levels (lines 0 to 15) and eight APIC request levels, which stand for global interrupt numbers 16 to 23. All outputs are levels: the block does no edge detection and takes no part in acknowledge.

The legacy side is programmable. Each PIRQ owns a routing byte that names a PIC line and carries a disable bit. Several PIRQs may share one PIC line, and that line is then the OR of their levels. The APIC side is fixed: PIRQ n always drives APIC line n (global interrupt 16+n), whatever its routing byte says. The SCI can be steered onto one of three PIC lines or one of two APIC lines, or parked nowhere. Software programs the nine control bytes through a simple write port. Every output is registered, and it follows its inputs one clock later.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte reads as disabled (value 0x80) and the SCI select is 0. So with any PIRQ pattern and SCI low, all PIC lines are 0, and with SCI high only PIC line 9 is set.
- R2: APIC output n equals PIRQ input n, regardless of that PIRQ's routing byte (bit n of `apic_irq_o` is global interrupt 16+n).
- R3: A write to address n (0..7) sets the routing byte of PIRQ n. Bits [3:0] name the PIC line, bit 7 set disables the route, and bits [6:4] have no effect.
- R4: A PIRQ whose routing byte has bit 7 set reaches no PIC line.
- R5: PIC line g is the OR of every enabled PIRQ whose line field equals g, plus the SCI when the SCI is selected onto g.
- R6: A write to address 8 sets the SCI select from bits [2:0]. The values 0, 1 and 2 OR the SCI into PIC lines 9, 10 and 11.
- R7: SCI select values 4 and 5 OR the SCI into APIC bits 4 and 5 (global interrupts 20 and 21). PIRQ E and F share these bits.
- R8: SCI select values 3, 6 and 7 are reserved and route the SCI to no output.
- R9: Writes to addresses 9 to 15 change no routing state.
- R10: Every output is registered. A change on `pirq_i` or `sci_i` shows at the outputs after the next rising clock edge. A register write takes effect on the outputs one edge after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pirq_i | input | 8 | PIRQ A..H request levels, bit 0 = A |
| sci_i | input | 1 | SCI request level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address: 0..7 routing bytes, 8 SCI select |
| wr_data_i | input | 8 | Register write data |
| pic_irq_o | output | 16 | Legacy PIC request levels, bit g = line g |
| apic_irq_o | output | 8 | APIC request levels, bit n = global interrupt 16+n |

## Verification
The bench builds the block with its default parameters: eight PIRQs and sixteen PIC lines. At that size every PIRQ can be routed to every PIC line in turn, every one of the 256 PIRQ patterns can be applied under several shared routing tables, and all eight SCI select codes can be tried with the SCI both low and high. The expected output vectors come from a small arithmetic model of the routing bytes that the bench keeps as it writes them. The same model covers the ignored addresses, the reserved select codes and the one-edge output latency.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

    localparam int IRQ_W      = 4;
    localparam int DATA_W     = 8;
    localparam int DIS_BIT    = 7;
    localparam int SEL_W      = 3;

    typedef struct packed {
        logic             dis;
        logic [IRQ_W-1:0] line;
    } route_t;

    localparam route_t ROUTE_RST = '{dis: 1'b1, line: '0};

    typedef enum logic [SEL_W-1:0] {
        SCI_PIC9   = 3'd0,
        SCI_PIC10  = 3'd1,
        SCI_PIC11  = 3'd2,
        SCI_RSV3   = 3'd3,
        SCI_APIC20 = 3'd4,
        SCI_APIC21 = 3'd5,
        SCI_RSV6   = 3'd6,
        SCI_RSV7   = 3'd7
    } sci_sel_e;

    typedef struct packed {
        logic             pic_hit;
        logic [IRQ_W-1:0] pic_line;
        logic             apic_hit;
        logic [2:0]       apic_idx;
    } sci_dest_t;

    function automatic sci_dest_t sci_decode(sci_sel_e sel);
        sci_dest_t d;
        d = '0;
        case (sel)
            SCI_PIC9:   begin d.pic_hit = 1'b1;  d.pic_line = 4'd9;  end
            SCI_PIC10:  begin d.pic_hit = 1'b1;  d.pic_line = 4'd10; end
            SCI_PIC11:  begin d.pic_hit = 1'b1;  d.pic_line = 4'd11; end
            SCI_APIC20: begin d.apic_hit = 1'b1; d.apic_idx = 3'd4;  end
            SCI_APIC21: begin d.apic_hit = 1'b1; d.apic_idx = 3'd5;  end
            default:    d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    output route_t [NUM_PIRQ-1:0]        routes_o,
    output sci_sel_e                     sci_sel_o
);

    localparam int CTRL_ADDR = NUM_PIRQ;

    logic unused_spare;
    assign unused_spare = ^wr_data_i[DIS_BIT-1:IRQ_W];

    route_t [NUM_PIRQ-1:0] route_q;
    sci_sel_e              sel_q;

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst) begin
                route_q[n] <= ROUTE_RST;
            end else if (wr_en_i && wr_addr_i == ADDR_W'(n)) begin
                route_q[n] <= '{dis: wr_data_i[DIS_BIT], line: wr_data_i[IRQ_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SCI_PIC9;
        end else if (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR)) begin
            sel_q <= sci_sel_e'(wr_data_i[SEL_W-1:0]);
        end
    end

    assign routes_o  = route_q;
    assign sci_sel_o = sel_q;

    // R9
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i > ADDR_W'(CTRL_ADDR)) |=> ($stable(route_q) && $stable(sel_q)));

    // R6
    sel_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR)) |=> (sel_q == $past(wr_data_i[SEL_W-1:0])));

endmodule

// File: rtl/pirq_pic_merge.sv
module pirq_pic_merge
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ  = 8,
    parameter int PIC_LINES = 16
) (
    input  logic [NUM_PIRQ-1:0]   pirq_i,
    input  route_t [NUM_PIRQ-1:0] routes_i,
    input  logic                  sci_i,
    input  sci_dest_t             sci_dest_i,
    output logic [PIC_LINES-1:0]  pic_o
);

    for (genvar g = 0; g < PIC_LINES; g++) begin : g_line
        always_comb begin
            pic_o[g] = sci_i && sci_dest_i.pic_hit && sci_dest_i.pic_line == IRQ_W'(g);
            for (int n = 0; n < NUM_PIRQ; n++) begin
                if (pirq_i[n] && !routes_i[n].dis && routes_i[n].line == IRQ_W'(g)) begin
                    pic_o[g] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pirq_apic_merge.sv
module pirq_apic_merge
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ = 8
) (
    input  logic [NUM_PIRQ-1:0] pirq_i,
    input  logic                sci_i,
    input  sci_dest_t           sci_dest_i,
    output logic [NUM_PIRQ-1:0] apic_o
);

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_pin
        assign apic_o[n] = pirq_i[n] |
                           (sci_i && sci_dest_i.apic_hit && sci_dest_i.apic_idx == 3'(n));
    end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ  = 8,
    parameter int PIC_LINES = 16,
    parameter int ADDR_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PIRQ-1:0]   pirq_i,
    input  logic                  sci_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic [PIC_LINES-1:0]  pic_irq_o,
    output logic [NUM_PIRQ-1:0]   apic_irq_o
);

    route_t [NUM_PIRQ-1:0] routes;
    sci_sel_e              sci_sel;
    sci_dest_t             sci_dest;
    logic [PIC_LINES-1:0]  pic_next;
    logic [NUM_PIRQ-1:0]   apic_next;
    logic                  live_q;

    pirq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .routes_o  (routes),
        .sci_sel_o (sci_sel)
    );

    assign sci_dest = sci_decode(sci_sel);

    pirq_pic_merge #(.NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES)) u_pic (
        .pirq_i     (pirq_i),
        .routes_i   (routes),
        .sci_i      (sci_i),
        .sci_dest_i (sci_dest),
        .pic_o      (pic_next)
    );

    pirq_apic_merge #(.NUM_PIRQ(NUM_PIRQ)) u_apic (
        .pirq_i     (pirq_i),
        .sci_i      (sci_i),
        .sci_dest_i (sci_dest),
        .apic_o     (apic_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pic_irq_o  <= '0;
            apic_irq_o <= '0;
            live_q     <= 1'b0;
        end else begin
            pic_irq_o  <= pic_next;
            apic_irq_o <= apic_next;
            live_q     <= 1'b1;
        end
    end

    // R2
    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_apic_chk
        apic_follow_chk: assert property (@(posedge clk) disable iff (rst || !live_q)
            $past(pirq_i[n]) |-> apic_irq_o[n]);
    end

    // R5
    quiet_chk: assert property (@(posedge clk) disable iff (rst || !live_q)
        ($past(pirq_i) == '0 && !$past(sci_i)) |-> (pic_irq_o == '0 && apic_irq_o == '0));

    // R6
    sci_pic9_chk: assert property (@(posedge clk) disable iff (rst || !live_q)
        $past(sci_i && sci_sel == SCI_PIC9) |-> pic_irq_o[9]);

    // R8
    sci_reserved_chk: assert property (@(posedge clk) disable iff (rst || !live_q)
        $past(pirq_i == '0 && (sci_sel == SCI_RSV3 || sci_sel == SCI_RSV6 || sci_sel == SCI_RSV7))
        |-> (pic_irq_o == '0 && apic_irq_o == '0));

endmodule

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pirq = '0;
    logic        sci = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] pic;
    logic [7:0]  apic;

    int checks = 0;
    int fails  = 0;

    logic [7:0] rt [8];
    logic [2:0] sel;

    always #5 clk = ~clk;

    pirq_router u_dut (
        .clk        (clk),
        .rst        (rst),
        .pirq_i     (pirq),
        .sci_i      (sci),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .pic_irq_o  (pic),
        .apic_irq_o (apic)
    );

    function automatic logic [15:0] m_pic(logic [7:0] p, logic s);
        logic [15:0] r = '0;
        for (int n = 0; n < 8; n++)
            if (p[n] && !rt[n][7]) r[rt[n][3:0]] = 1'b1;
        if (s) begin
            if (sel == 3'd0) r[9]  = 1'b1;
            if (sel == 3'd1) r[10] = 1'b1;
            if (sel == 3'd2) r[11] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [7:0] m_apic(logic [7:0] p, logic s);
        logic [7:0] r = p;
        if (s && sel == 3'd4) r[4] = 1'b1;
        if (s && sel == 3'd5) r[5] = 1'b1;
        return r;
    endfunction

    task automatic check(string req, logic [15:0] ep, logic [7:0] ea);
        checks++;
        if (pic !== ep || apic !== ea) begin
            fails++;
            $display("FAIL %s: pic=%h apic=%h expected pic=%h apic=%h", req, pic, apic, ep, ea);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4'd8) rt[a] = d;
        else if (a == 4'd8) sel = d[2:0];
    endtask

    task automatic apply(logic [7:0] p, logic s);
        @(negedge clk);
        pirq = p; sci = s;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int n = 0; n < 8; n++) rt[n] = 8'h80;
        sel = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, quiet and with all PIRQs high
        apply(8'h00, 1'b0);
        check("R1 reset quiet", 16'h0000, 8'h00);
        apply(8'hFF, 1'b0);
        check("R1 all disabled, R2 apic follows", 16'h0000, 8'hFF);
        apply(8'h00, 1'b1);
        check("R1 default sci to pic 9", 16'h0200, 8'h00);

        // R3/R4: every PIRQ to every line, then disabled
        for (int n = 0; n < 8; n++) begin
            for (int g = 0; g < 16; g++) begin
                wr(4'(n), 8'(g));
                apply(8'(1 << n), 1'b0);
                check("R3 single route", m_pic(8'(1 << n), 1'b0), m_apic(8'(1 << n), 1'b0));
                wr(4'(n), 8'h80 | 8'(g));
                apply(8'(1 << n), 1'b0);
                check("R4 disabled route", 16'h0000, 8'(1 << n));
            end
        end

        // R5: shared routing tables over all PIRQ patterns, spare bits set
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 8; n++)
                wr(4'(n), (((n + k) % 3 == 0) ? 8'h80 : 8'h00) | 8'h50 | 8'((n * 3 + k * 5) % 16));
            for (int p = 0; p < 256; p++) begin
                apply(8'(p), 1'(p[0] ^ p[3]));
                check("R5 shared or", m_pic(8'(p), 1'(p[0] ^ p[3])), m_apic(8'(p), 1'(p[0] ^ p[3])));
            end
        end

        // R6/R7/R8: all select codes
        for (int s = 0; s < 8; s++) begin
            wr(4'd8, 8'hF8 | 8'(s));
            apply(8'h00, 1'b1);
            check(s < 3 ? "R6 sci pic" : (s == 4 || s == 5) ? "R7 sci apic" : "R8 sci reserved",
                  m_pic(8'h00, 1'b1), m_apic(8'h00, 1'b1));
            apply(8'h00, 1'b0);
            check("R8 sci low", 16'h0000, 8'h00);
            apply(8'hA5, 1'b1);
            check("R7 sci with pirqs", m_pic(8'hA5, 1'b1), m_apic(8'hA5, 1'b1));
        end

        // R9: writes to unused addresses change nothing
        wr(4'd8, 8'h01);
        for (int n = 0; n < 8; n++) wr(4'(n), 8'h80);
        for (int a = 9; a < 16; a++) wr(4'(a), 8'h03);
        apply(8'hFF, 1'b1);
        check("R9 ignored writes", 16'h0400, 8'hFF);

        // R10: one-edge latency for inputs and writes
        apply(8'h00, 1'b0);
        @(negedge clk);
        pirq = 8'h01;
        #1;
        check("R10 not before edge", 16'h0000, 8'h00);
        @(posedge clk);
        #1;
        check("R10 after edge", 16'h0000, 8'h01);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h06;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        rt[0] = 8'h06;
        check("R10 write not yet visible", 16'h0000, 8'h01);
        @(posedge clk);
        #1;
        check("R10 write visible", 16'h0040, 8'h01);

        finish_run();
    end

endmodule